// File: doc/BRIEF.md
# Status Register Write-Protection Controller

This block keeps the main status register and a secondary sector-lock register of a serial flash device, and decides whether a program or erase aimed at a given address range may go ahead. A command decoder feeds it one-cycle strobes at the end of each instruction (chip select rising), together with the instruction kind, and for a status write the collected data bits and how many of them arrived. The block applies write-enable, write-disable, status-arm and status-write instructions, and it honours a one-way lock of the protection bits that is gated by the active-low write-protect pin.

For a program or erase, the array controller presents the operation kind and its address. The block widens that address to the full target range (one byte, a 4 KiB sector, a 32 KiB block, a 64 KiB block or the whole array) and raises the allow output only when the write latch is set, the array is idle, and the range misses every protected area. Protected areas are an upper part of the array picked by a two-bit field, and the lowest and highest 4 KiB sectors, each lockable on its own.

Top module: `sr_wp_ctrl`

## Requirements
- R1: After reset the main register reads 0x0C (both protection-level bits set, all else 0) and the secondary register reads 0x00.
- R2: At an instruction end with op code 1 (write enable) the write latch (main bit 1) is set; op code 2 (write disable) clears both the write latch and the AAI bit (main bit 6); a program/erase completion pulse clears the write latch; the AAI start pulse sets bit 6.
- R3: Main bit 0 follows the busy input one cycle later; main bits 4-5 and secondary bits 0-1 and 4-7 always read 0; the busy, latch and AAI bits are never taken from status-write data.
- R4: A status write (op code 4) takes effect only when the instruction ending just before it was op code 3 (status arm) or op code 1; any other instruction in between (op code 0 stands for all others) disarms it.
- R5: With 8 data bits the main register takes bits 2, 3 and 7 of data[7:0] and the secondary register is untouched; with 16 data bits the main register takes data[15:8] and the secondary lock bits take bits 2 (top) and 3 (bottom) of data[7:0]; any other bit count changes nothing.
- R6: The write latch is clear after every status-write instruction end, whether or not the write took effect.
- R7: When the write-protect pin is low and the lock bit (main bit 7) is 1, a status write changes nothing; with the pin low the lock bit can still go from 0 to 1; with the pin high the lock bit has no effect and can be cleared.
- R8: Protection level 01 guards the top quarter of the array (0x30000 and up for 18 address bits), 10 the top half (0x20000 and up), 11 all of it, 00 nothing.
- R9: With the top lock set, any range reaching the highest 4 KiB sector is denied; with the bottom lock set, any range reaching the lowest 4 KiB sector is denied.
- R10: Query kind 0 covers one byte, 1 the aligned 4 KiB sector, 2 the aligned 32 KiB block, 3 the aligned 64 KiB block holding the address; protection applies to the whole range.
- R11: Query kind 4 (whole array) is allowed only when the protection level is 00 and neither sector lock is set; kinds 5-7 are always denied.
- R12: Allow is low whenever the write latch is clear or the busy input is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instr_end_i | input | 1 | One-cycle pulse at the end of an instruction |
| instr_op_i | input | 3 | Kind of the ending instruction |
| wr_bits_i | input | CNT_W | Number of data bits received by a status write |
| wr_data_i | input | 16 | Status-write data, last bit received in bit 0 |
| wr_done_i | input | 1 | Program or erase finished |
| aai_start_i | input | 1 | Sequential programming mode entered |
| wp_n_i | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Array operation in progress |
| q_kind_i | input | 3 | Kind of the queried program/erase |
| q_addr_i | input | ADDR_W | Address of the queried program/erase |
| status_o | output | 8 | Main status register |
| status1_o | output | 8 | Secondary sector-lock register |
| allow_o | output | 1 | Queried operation may proceed |

## Verification
The bench drives every pin/lock combination, including the lock being set while the pin is already low, and checks that a design which only compared the new lock value or ignored the pin would either refuse legal writes or let a locked register change. It sends unarmed writes, writes disarmed by an unrelated instruction in between and writes with a wrong bit count; a design that tracked only the latch, or accepted any non-zero count, would move the protection bits. Queries hit the first and last address on each side of every region boundary, and sector and block queries whose address is clear of a locked sector while their widened range is not, which catches a design that tests only the raw address.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [2:0] {
        OP_OTHER = 3'd0,
        OP_WREN  = 3'd1,
        OP_WRDI  = 3'd2,
        OP_ARM   = 3'd3,
        OP_WRSR  = 3'd4
    } op_t;

    typedef enum logic [2:0] {
        QK_BYTE  = 3'd0,
        QK_SECT  = 3'd1,
        QK_BLK32 = 3'd2,
        QK_BLK64 = 3'd3,
        QK_CHIP  = 3'd4
    } qkind_t;

    typedef struct packed {
        logic       busy;
        logic       wel;
        logic [1:0] bp;
        logic       aai;
        logic       bpl;
        logic       tsp;
        logic       bsp;
        logic       armed;
    } sr_state_t;

    localparam int DATA_W = 16;

endpackage

// File: rtl/sr_range_gen.sv
module sr_range_gen
    import sr_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int SECT_W  = 12,
    parameter int BLKS_W  = 15,
    parameter int BLKL_W  = 16
) (
    input  logic [2:0]        kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] lo_o,
    output logic [ADDR_W-1:0] hi_o,
    output logic              valid_o
);
    localparam logic [ADDR_W-1:0] M_SECT = ADDR_W'((64'd1 << SECT_W) - 64'd1);
    localparam logic [ADDR_W-1:0] M_BLKS = ADDR_W'((64'd1 << BLKS_W) - 64'd1);
    localparam logic [ADDR_W-1:0] M_BLKL = ADDR_W'((64'd1 << BLKL_W) - 64'd1);

    logic [ADDR_W-1:0] mask;

    always_comb begin
        mask    = '0;
        valid_o = 1'b1;
        case (qkind_t'(kind_i))
            QK_BYTE:  mask = '0;
            QK_SECT:  mask = M_SECT;
            QK_BLK32: mask = M_BLKS;
            QK_BLK64: mask = M_BLKL;
            QK_CHIP:  mask = '1;
            default: begin
                mask    = '0;
                valid_o = 1'b0;
            end
        endcase
        lo_o = addr_i & ~mask;
        hi_o = addr_i | mask;
    end

endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int SECT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        kind_i,
    input  logic [ADDR_W-1:0] lo_i,
    input  logic [ADDR_W-1:0] hi_i,
    input  logic              valid_i,
    input  logic [1:0]        bp_i,
    input  logic              tsp_i,
    input  logic              bsp_i,
    input  logic              wel_i,
    input  logic              busy_i,
    output logic              allow_o
);
    localparam logic [ADDR_W-1:0] QTR3_LO = {2'b11, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] HALF_LO = {2'b10, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] TOP_LO  = {{(ADDR_W-SECT_W){1'b1}}, {SECT_W{1'b0}}};

    logic [ADDR_W-1:0] bp_lo;
    logic              bp_hit;
    logic              top_hit;
    logic              bot_hit;

    always_comb begin
        case (bp_i)
            2'b01:   bp_lo = QTR3_LO;
            2'b10:   bp_lo = HALF_LO;
            default: bp_lo = '0;
        endcase
        bp_hit  = (bp_i != 2'b00) && (hi_i >= bp_lo);
        top_hit = tsp_i && (hi_i >= TOP_LO);
        bot_hit = bsp_i && (lo_i[ADDR_W-1:SECT_W] == '0);
        allow_o = valid_i && wel_i && !busy_i && !bp_hit && !top_hit && !bot_hit;
    end

    AST_CHIP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (qkind_t'(kind_i) == QK_CHIP && allow_o) |-> (bp_i == 2'b00 && !tsp_i && !bsp_i)); // R11
    AST_IDLE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wel_i || busy_i) |-> !allow_o); // R12
    AST_TOP_SECT_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (tsp_i && hi_i >= TOP_LO) |-> !allow_o); // R9

endmodule

// File: rtl/sr_regs.sv
module sr_regs
    import sr_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_end_i,
    input  logic [2:0]        instr_op_i,
    input  logic [CNT_W-1:0]  wr_bits_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              wr_done_i,
    input  logic              aai_start_i,
    input  logic              wp_n_i,
    input  logic              busy_i,
    output sr_state_t         st_o
);
    localparam logic [CNT_W-1:0] BITS_BYTE = CNT_W'(8);
    localparam logic [CNT_W-1:0] BITS_WORD = CNT_W'(16);
    localparam sr_state_t ST_RESET = '{busy: 1'b0, wel: 1'b0, bp: 2'b11, aai: 1'b0,
                                       bpl: 1'b0, tsp: 1'b0, bsp: 1'b0, armed: 1'b0};

    sr_state_t st_d, st_q;
    op_t       op;
    logic      locked;
    logic      fmt_byte;
    logic      fmt_word;
    logic [7:0] main_byte;

    always_comb begin
        op        = op_t'(instr_op_i);
        locked    = !wp_n_i && st_q.bpl;
        fmt_byte  = (wr_bits_i == BITS_BYTE);
        fmt_word  = (wr_bits_i == BITS_WORD);
        main_byte = fmt_word ? wr_data_i[15:8] : wr_data_i[7:0];

        st_d      = st_q;
        st_d.busy = busy_i;
        if (aai_start_i) st_d.aai = 1'b1;
        if (wr_done_i)   st_d.wel = 1'b0;

        if (instr_end_i) begin
            case (op)
                OP_WREN: begin
                    st_d.wel   = 1'b1;
                    st_d.armed = 1'b1;
                end
                OP_ARM: begin
                    st_d.armed = 1'b1;
                end
                OP_WRDI: begin
                    st_d.wel   = 1'b0;
                    st_d.aai   = 1'b0;
                    st_d.armed = 1'b0;
                end
                OP_WRSR: begin
                    st_d.wel   = 1'b0;
                    st_d.armed = 1'b0;
                    if (st_q.armed && !locked && (fmt_byte || fmt_word)) begin
                        st_d.bp  = main_byte[3:2];
                        st_d.bpl = main_byte[7];
                        if (fmt_word) begin
                            st_d.tsp = wr_data_i[2];
                            st_d.bsp = wr_data_i[3];
                        end
                    end
                end
                default: begin
                    st_d.armed = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign st_o = st_q;

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n_i && st_q.bpl) |=> $stable({st_q.bp, st_q.bpl, st_q.tsp, st_q.bsp})); // R7
    AST_UNARMED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end_i && op_t'(instr_op_i) == OP_WRSR && !st_q.armed)
        |=> $stable({st_q.bp, st_q.bpl, st_q.tsp, st_q.bsp})); // R4
    AST_WRSR_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end_i && op_t'(instr_op_i) == OP_WRSR) |=> !st_q.wel); // R6
    AST_WRDI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end_i && op_t'(instr_op_i) == OP_WRDI) |=> (!st_q.wel && !st_q.aai)); // R2
    AST_BAD_COUNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end_i && op_t'(instr_op_i) == OP_WRSR
         && wr_bits_i != BITS_BYTE && wr_bits_i != BITS_WORD)
        |=> $stable({st_q.bp, st_q.bpl, st_q.tsp, st_q.bsp})); // R5

endmodule

// File: rtl/sr_wp_ctrl.sv
module sr_wp_ctrl
    import sr_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int SECT_W = 12,
    parameter int BLKS_W = 15,
    parameter int BLKL_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_end_i,
    input  logic [2:0]        instr_op_i,
    input  logic [CNT_W-1:0]  wr_bits_i,
    input  logic [15:0]       wr_data_i,
    input  logic              wr_done_i,
    input  logic              aai_start_i,
    input  logic              wp_n_i,
    input  logic              busy_i,
    input  logic [2:0]        q_kind_i,
    input  logic [ADDR_W-1:0] q_addr_i,
    output logic [7:0]        status_o,
    output logic [7:0]        status1_o,
    output logic              allow_o
);
    sr_state_t         st;
    logic [ADDR_W-1:0] rng_lo;
    logic [ADDR_W-1:0] rng_hi;
    logic              rng_valid;

    sr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_end_i (instr_end_i),
        .instr_op_i  (instr_op_i),
        .wr_bits_i   (wr_bits_i),
        .wr_data_i   (wr_data_i),
        .wr_done_i   (wr_done_i),
        .aai_start_i (aai_start_i),
        .wp_n_i      (wp_n_i),
        .busy_i      (busy_i),
        .st_o        (st)
    );

    sr_range_gen #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W),
        .BLKS_W (BLKS_W),
        .BLKL_W (BLKL_W)
    ) u_range (
        .kind_i  (q_kind_i),
        .addr_i  (q_addr_i),
        .lo_o    (rng_lo),
        .hi_o    (rng_hi),
        .valid_o (rng_valid)
    );

    sr_guard #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W)
    ) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind_i  (q_kind_i),
        .lo_i    (rng_lo),
        .hi_i    (rng_hi),
        .valid_i (rng_valid),
        .bp_i    (st.bp),
        .tsp_i   (st.tsp),
        .bsp_i   (st.bsp),
        .wel_i   (st.wel),
        .busy_i  (busy_i),
        .allow_o (allow_o)
    );

    assign status_o  = {st.bpl, st.aai, 2'b00, st.bp, st.wel, st.busy};
    assign status1_o = {4'b0000, st.bsp, st.tsp, 2'b00};

    AST_BUSY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> status_o[0]); // R3

endmodule

// File: tb/sr_wp_ctrl_bench.sv
`timescale 1ns/1ps
module sr_wp_ctrl_bench;

    localparam int ADDR_W = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              instr_end = 1'b0;
    logic [2:0]        instr_op = 3'd0;
    logic [4:0]        wr_bits = 5'd0;
    logic [15:0]       wr_data = 16'h0;
    logic              wr_done = 1'b0;
    logic              aai_start = 1'b0;
    logic              wp_n = 1'b1;
    logic              busy = 1'b0;
    logic [2:0]        q_kind = 3'd0;
    logic [ADDR_W-1:0] q_addr = '0;
    logic [7:0]        status;
    logic [7:0]        status1;
    logic              allow;

    always #2.5 clk = ~clk;

    sr_wp_ctrl u_sr_wp_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_end_i (instr_end),
        .instr_op_i  (instr_op),
        .wr_bits_i   (wr_bits),
        .wr_data_i   (wr_data),
        .wr_done_i   (wr_done),
        .aai_start_i (aai_start),
        .wp_n_i      (wp_n),
        .busy_i      (busy),
        .q_kind_i    (q_kind),
        .q_addr_i    (q_addr),
        .status_o    (status),
        .status1_o   (status1),
        .allow_o     (allow)
    );

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];
    item_t it;
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // Monitor: consumes expected items at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.sel)
                0:       act = status;
                1:       act = status1;
                default: act = {7'd0, allow};
            endcase
            n_vec++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic expect_item(input int sel, input logic [7:0] exp, input string req);
        item_t e;
        e.sel = sel;
        e.exp = exp;
        e.req = req;
        sb_q.push_back(e);
        tick();
    endtask

    task automatic instr(input logic [2:0] op);
        instr_op  = op;
        instr_end = 1'b1;
        tick();
        instr_end = 1'b0;
        instr_op  = 3'd0;
    endtask

    task automatic wrsr(input logic [4:0] nbits, input logic [15:0] data);
        wr_bits = nbits;
        wr_data = data;
        instr(3'd4);
        wr_bits = 5'd0;
        wr_data = 16'h0;
    endtask

    task automatic query(input logic [2:0] kind, input logic [ADDR_W-1:0] addr,
                         input logic exp, input string req);
        q_kind = kind;
        q_addr = addr;
        #1;
        expect_item(2, {7'd0, exp}, req);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // Reset state
        expect_item(0, 8'h0C, "R1 main reset");
        expect_item(1, 8'h00, "R1 secondary reset");
        query(3'd0, 18'h00000, 1'b0, "R12 no latch");

        // Latch, armed byte write
        instr(3'd1);
        expect_item(0, 8'h0E, "R2 wren sets latch");
        query(3'd0, 18'h00000, 1'b0, "R8 level 11 guards all");
        wrsr(5'd8, 16'h0000);
        expect_item(0, 8'h00, "R6 latch cleared, R5 byte write");

        // Arming rules
        wrsr(5'd8, 16'h000C);
        expect_item(0, 8'h00, "R4 unarmed write ignored");
        instr(3'd3);
        instr(3'd0);
        wrsr(5'd8, 16'h000C);
        expect_item(0, 8'h00, "R4 disarmed by other instruction");
        instr(3'd3);
        wrsr(5'd8, 16'h0004);
        expect_item(0, 8'h04, "R4 arm op enables write");

        // Format
        instr(3'd3);
        wrsr(5'd12, 16'h0000);
        expect_item(0, 8'h04, "R5 bad bit count ignored");
        instr(3'd1);
        wrsr(5'd16, 16'h73FF);
        expect_item(0, 8'h00, "R3 read-only bits not written");
        expect_item(1, 8'h0C, "R5 word sets sector locks, R3 reserved zero");
        instr(3'd3);
        wrsr(5'd8, 16'h0000);
        expect_item(1, 8'h0C, "R5 byte leaves secondary");

        // Sector locks and range widening, level 00
        instr(3'd1);
        expect_item(0, 8'h02, "R2 latch set again");
        query(3'd0, 18'h00FFF, 1'b0, "R9 bottom sector last byte");
        query(3'd0, 18'h01000, 1'b1, "R9 above bottom sector");
        query(3'd0, 18'h3EFFF, 1'b1, "R9 below top sector");
        query(3'd0, 18'h3F000, 1'b0, "R9 top sector first byte");
        query(3'd2, 18'h07FFF, 1'b0, "R10 32K block reaches bottom");
        query(3'd0, 18'h07FFF, 1'b1, "R10 byte in same block");
        query(3'd3, 18'h30000, 1'b0, "R10 64K block reaches top");
        query(3'd1, 18'h01FFF, 1'b1, "R10 sector clear of locks");
        query(3'd1, 18'h00800, 1'b0, "R10 sector is bottom");
        query(3'd4, 18'h12345, 1'b0, "R11 chip with sector lock");
        query(3'd5, 18'h12345, 1'b0, "R11 undefined kind");

        // Clear locks, chip and busy
        wrsr(5'd16, 16'h0000);
        expect_item(1, 8'h00, "R5 word clears locks");
        instr(3'd1);
        query(3'd4, 18'h00000, 1'b1, "R11 chip allowed");
        busy = 1'b1;
        query(3'd4, 18'h00000, 1'b0, "R12 busy denies");
        expect_item(0, 8'h03, "R3 busy mirrored");
        busy = 1'b0;
        tick();

        // Level 01
        wrsr(5'd8, 16'h0004);
        instr(3'd1);
        expect_item(0, 8'h06, "R8 level 01 set");
        query(3'd0, 18'h2FFFF, 1'b1, "R8 below top quarter");
        query(3'd0, 18'h30000, 1'b0, "R8 top quarter start");
        query(3'd3, 18'h2ABCD, 1'b1, "R10 64K block below quarter");
        query(3'd4, 18'h00000, 1'b0, "R11 chip with level 01");
        // Level 10
        wrsr(5'd8, 16'h0008);
        instr(3'd1);
        expect_item(0, 8'h0A, "R8 level 10 set");
        query(3'd0, 18'h1FFFF, 1'b1, "R8 below top half");
        query(3'd0, 18'h20000, 1'b0, "R8 top half start");
        query(3'd2, 18'h1F000, 1'b1, "R10 32K block below half");
        // Level 11
        wrsr(5'd8, 16'h000C);
        instr(3'd1);
        query(3'd0, 18'h00000, 1'b0, "R8 level 11 first byte");

        // Lock behaviour
        wrsr(5'd8, 16'h0080);
        expect_item(0, 8'h80, "R7 lock set with pin high");
        instr(3'd1);
        wp_n = 1'b0;
        wrsr(5'd8, 16'h000C);
        expect_item(0, 8'h80, "R7 locked byte write ignored");
        instr(3'd3);
        wrsr(5'd16, 16'h000C);
        expect_item(1, 8'h00, "R7 locked word write ignored");
        wp_n = 1'b1;
        instr(3'd3);
        wrsr(5'd8, 16'h0000);
        expect_item(0, 8'h00, "R7 pin high clears lock");
        wp_n = 1'b0;
        instr(3'd3);
        wrsr(5'd8, 16'h0088);
        expect_item(0, 8'h88, "R7 lock 0 to 1 with pin low");
        instr(3'd3);
        wrsr(5'd8, 16'h0000);
        expect_item(0, 8'h88, "R7 lock 1 to 0 refused");
        wp_n = 1'b1;
        instr(3'd3);
        wrsr(5'd8, 16'h0000);
        expect_item(0, 8'h00, "R7 lock ignored with pin high");

        // AAI bit and completion
        aai_start = 1'b1;
        tick();
        aai_start = 1'b0;
        expect_item(0, 8'h40, "R2 aai start");
        instr(3'd2);
        expect_item(0, 8'h00, "R2 wrdi clears aai");
        instr(3'd1);
        wr_done = 1'b1;
        tick();
        wr_done = 1'b0;
        expect_item(0, 8'h00, "R2 completion clears latch");

        tick();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule